// File: doc/BRIEF.md
# Link Mode-Switch Initiator Controller

This block is the initiating side of a three-phase handshake that re-evaluates the modulation of a point-to-point radio link and changes it when needed. An interval timer starts the handshake on its own. A manual request loads the same timer with a much shorter expiry, so the handshake starts almost at once. While the handshake runs, the block leaves normal operation: it raises `busy` and blocks normal data transmission.

In the opening phase the block keeps requesting Start packets until the peer answers with Ack Start. It then requests a programmed number of Measurement packets. After those it keeps requesting End packets until a Result End reply returns the peer's error count. It compares that count against a programmed limit and picks the next mode. QPSK moves up to QAM-16 when the count is below the limit, and QAM-16 drops back to QPSK when the count is above it. The block then falls silent, so that the peer can infer the change from the silence. It answers the peer's Synch with one Ack Synch and returns to normal operation.

Packet type codes travel as one byte. Replies count only when they carry the all-ones broadcast destination, reported here as a flag, and when their type is the one the current phase expects. The modem, the checksum and the framing lie outside this block.

Top module: `msw_initiator_ctrl`

## Requirements
- R1: After reset or on return to normal operation, the interval timer holds `AUTO_INTERVAL`. `busy` rises on the (`AUTO_INTERVAL`+1)-th rising clock edge spent in normal operation.
- R2: A `manual_req` captured in normal operation while the timer holds more than `MANUAL_DELAY` reloads it with `MANUAL_DELAY`. `busy` then rises on the (`MANUAL_DELAY`+2)-th edge, counting the capturing edge as the first.
- R3: When triggered, the block requests type 2 (Start). After each accepted Start with no reply, the request is withdrawn for `RETX_CYCLES`+1 cycles and then made again. Only types 2, 4, 5 and 8 are ever requested.
- R4: On an accepted type 3 (Ack Start), `cfg_meas_count` is latched. Exactly that many type 4 (Measurement) packets are requested, followed by type 5 (End). A count of zero goes straight to End.
- R5: End is re-requested with the same withdrawn gap of `RETX_CYCLES`+1 cycles until type 6 (Result End) arrives.
- R6: `link_mode` is 0 for QPSK and 1 for QAM-16. On an accepted Result End with error count `rx_payload`, the mode goes 0→1 if the count is below `cfg_err_limit`, goes 1→0 if the count is above it, and otherwise stays. The change shows on the edge that accepts the reply.
- R7: After Result End, no request is made until a type 7 (Synch) arrives. The block then requests exactly one type 8 (Ack Synch), and `busy` falls on the edge that accepts it.
- R8: A received packet is ignored unless `rx_valid` and `rx_bcast` are both high and its type is the one the current phase waits for. An ignored packet changes neither the requests nor `link_mode`.
- R9: `data_tx_grant` follows `data_tx_req` while `busy` is low and is 0 while `busy` is high.
- R10: A request held without `tx_ready` keeps `tx_valid` high and `tx_type` unchanged.
- R11: During and right after reset, `busy` is 0, `tx_valid` is 0 and `link_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| manual_req | input | 1 | Manual request for a short-expiry trigger |
| cfg_meas_count | input | CNT_W | Number of Measurement packets per handshake |
| cfg_err_limit | input | CNT_W | Error-count limit for the mode decision |
| tx_valid | output | 1 | Protocol packet request |
| tx_type | output | 8 | Type code of the requested packet |
| tx_ready | input | 1 | Packet request accepted this cycle |
| rx_valid | input | 1 | Received packet present |
| rx_bcast | input | 1 | Received packet carried the all-ones destination |
| rx_type | input | 8 | Received packet type code |
| rx_payload | input | CNT_W | Received payload (error count in Result End) |
| data_tx_req | input | 1 | Normal data transmission request |
| data_tx_grant | output | 1 | Normal data transmission allowed |
| link_mode | output | 1 | Current mode, 0 QPSK, 1 QAM-16 |
| busy | output | 1 | Handshake in progress |

## Verification
A received reply is taken on the next rising edge. The bench therefore drives it at a falling edge, removes it one falling edge later, and checks `link_mode`, `tx_valid` and `busy` at that falling edge: the new state is already visible there. The trigger results are due exactly `AUTO_INTERVAL`+1 or `MANUAL_DELAY`+2 edges after their start, and the bench counts posedges to that edge and samples on both sides of it. Retransmission gaps are measured as the number of falling edges with the request withdrawn, which must equal `RETX_CYCLES`+1. Measurement packets are counted only on falling edges where both request and ready are high.

// File: rtl/msw_pkg.sv
// Shared types for the mode-switch initiator: packet codes, FSM states, modes.
package msw_pkg;

    // One-byte packet type codes; values are fixed by the peer's decoder
    typedef enum logic [7:0] {
        PKT_DATA       = 8'd0,
        PKT_ACK        = 8'd1,
        PKT_START      = 8'd2,
        PKT_ACK_START  = 8'd3,
        PKT_MEAS       = 8'd4,
        PKT_END        = 8'd5,
        PKT_RESULT_END = 8'd6,
        PKT_SYNCH      = 8'd7,
        PKT_ACK_SYNCH  = 8'd8,
        PKT_ROLLBACK   = 8'd9,
        PKT_ACK_ROLL   = 8'd10
    } pkt_type_e;

    // Handshake controller states
    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_START_TX,
        ST_START_WAIT,
        ST_MEAS_TX,
        ST_END_TX,
        ST_END_WAIT,
        ST_QUIET,
        ST_ACKSYN_TX
    } hs_state_e;

    // Link modulation mode
    typedef enum logic {
        MODE_QPSK  = 1'b0,
        MODE_QAM16 = 1'b1
    } link_mode_e;

endpackage

// File: rtl/msw_trigger_timer.sv
// Shared handshake trigger timer.
// Counts down while enabled (normal operation) and pulses expire at zero.
// A manual request shortens the remaining time to MANUAL_DELAY.
// Assumes: MANUAL_DELAY < AUTO_INTERVAL; disabled time reloads AUTO_INTERVAL.
module msw_trigger_timer #(
    parameter int AUTO_INTERVAL = 300,
    parameter int MANUAL_DELAY  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic manual_req,
    output logic expire
);
    localparam int TW = $clog2(AUTO_INTERVAL + 1);
    localparam logic [TW-1:0] LOAD_AUTO = TW'(AUTO_INTERVAL);
    localparam logic [TW-1:0] LOAD_MAN  = TW'(MANUAL_DELAY);

    logic [TW-1:0] remain;

    // Expiry is a zero count while enabled
    assign expire = enable && (remain == '0);

    // Countdown with auto reload and manual shortening
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= LOAD_AUTO;
        end else if (!enable || expire) begin
            remain <= LOAD_AUTO;
        end else if (manual_req && (remain > LOAD_MAN)) begin
            remain <= LOAD_MAN;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/msw_retx_timer.sv
// Retransmit timer for protocol packets.
// Loaded when a packet is accepted, counts while the controller waits,
// and flags expiry RETX_CYCLES+1 cycles of waiting after the load.
// Assumes: load and run are never high in the same cycle.
module msw_retx_timer #(
    parameter int RETX_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int RW = $clog2(RETX_CYCLES + 1);
    localparam logic [RW-1:0] LOAD_VAL = RW'(RETX_CYCLES);

    logic [RW-1:0] remain;

    // Expiry only while waiting
    assign expire = run && (remain == '0);

    // Load on acceptance, count down while waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= LOAD_VAL;
        end else if (load) begin
            remain <= LOAD_VAL;
        end else if (run && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/msw_mode_decide.sv
// Threshold mode decision from a returned error count.
// QPSK steps up when the count is strictly below the limit; QAM-16 steps
// down when strictly above; equality keeps the current mode.
module msw_mode_decide #(
    parameter int CNT_W = 16
) (
    input  msw_pkg::link_mode_e cur_mode,
    input  logic [CNT_W-1:0]    err_count,
    input  logic [CNT_W-1:0]    err_limit,
    output msw_pkg::link_mode_e next_mode
);
    import msw_pkg::*;

    // Pure comparison table
    always_comb begin
        next_mode = cur_mode;
        if ((cur_mode == MODE_QPSK) && (err_count < err_limit)) begin
            next_mode = MODE_QAM16;
        end else if ((cur_mode == MODE_QAM16) && (err_count > err_limit)) begin
            next_mode = MODE_QPSK;
        end
    end
endmodule

// File: rtl/msw_initiator_ctrl.sv
// Initiating-side mode-switch handshake controller.
// Triggered by the shared timer, it requests Start until Ack Start, then a
// latched number of Measurement packets, then End until Result End. It
// applies the mode decision, stays silent until Synch, answers with one
// Ack Synch, and returns to normal operation.
// Assumes: rx_bcast reports an all-ones destination; tx_type is only
// meaningful while tx_valid is high.
module msw_initiator_ctrl #(
    parameter int AUTO_INTERVAL = 300,
    parameter int MANUAL_DELAY  = 16,
    parameter int RETX_CYCLES   = 10,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             manual_req,
    input  logic [CNT_W-1:0] cfg_meas_count,
    input  logic [CNT_W-1:0] cfg_err_limit,
    output logic             tx_valid,
    output logic [7:0]       tx_type,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic             rx_bcast,
    input  logic [7:0]       rx_type,
    input  logic [CNT_W-1:0] rx_payload,
    input  logic             data_tx_req,
    output logic             data_tx_grant,
    output logic             link_mode,
    output logic             busy
);
    import msw_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    hs_state_e        state, state_nx;
    logic [CNT_W-1:0] meas_left, meas_left_nx;
    link_mode_e       mode_q, mode_decided;
    logic             trig_expire, retx_expire, retx_load, retx_run;
    logic             tx_fire, rx_proto;
    logic             hit_ack_start, hit_result, hit_synch;

    // Protocol reply qualification: broadcast destination and type above Ack
    assign rx_proto      = rx_valid && rx_bcast && (rx_type > PKT_ACK);
    assign hit_ack_start = rx_proto && (rx_type == PKT_ACK_START);
    assign hit_result    = rx_proto && (rx_type == PKT_RESULT_END);
    assign hit_synch     = rx_proto && (rx_type == PKT_SYNCH);

    // Request decode from state only
    always_comb begin
        tx_valid = 1'b1;
        tx_type  = PKT_DATA;
        unique case (state)
            ST_START_TX:  tx_type = PKT_START;
            ST_MEAS_TX:   tx_type = PKT_MEAS;
            ST_END_TX:    tx_type = PKT_END;
            ST_ACKSYN_TX: tx_type = PKT_ACK_SYNCH;
            default:      tx_valid = 1'b0;
        endcase
    end

    assign tx_fire       = tx_valid && tx_ready;
    assign busy          = (state != ST_NORMAL);
    assign data_tx_grant = data_tx_req && !busy;
    assign link_mode     = mode_q;

    assign retx_run  = (state == ST_START_WAIT) || (state == ST_END_WAIT);
    assign retx_load = tx_fire &&
                       (((state == ST_START_TX) && !hit_ack_start) ||
                        ((state == ST_END_TX) && !hit_result));

    msw_trigger_timer #(
        .AUTO_INTERVAL (AUTO_INTERVAL),
        .MANUAL_DELAY  (MANUAL_DELAY)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (state == ST_NORMAL),
        .manual_req (manual_req),
        .expire     (trig_expire)
    );

    msw_retx_timer #(
        .RETX_CYCLES (RETX_CYCLES)
    ) u_retx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (retx_load),
        .run    (retx_run),
        .expire (retx_expire)
    );

    msw_mode_decide #(
        .CNT_W (CNT_W)
    ) u_decide (
        .cur_mode  (mode_q),
        .err_count (rx_payload),
        .err_limit (cfg_err_limit),
        .next_mode (mode_decided)
    );

    // Next-state and measurement counter logic
    always_comb begin
        state_nx     = state;
        meas_left_nx = meas_left;
        unique case (state)
            ST_NORMAL: begin
                if (trig_expire) state_nx = ST_START_TX;
            end
            ST_START_TX, ST_START_WAIT: begin
                if (hit_ack_start) begin
                    meas_left_nx = cfg_meas_count;
                    state_nx     = (cfg_meas_count == '0) ? ST_END_TX : ST_MEAS_TX;
                end else if ((state == ST_START_TX) && tx_fire) begin
                    state_nx = ST_START_WAIT;
                end else if (retx_expire) begin
                    state_nx = ST_START_TX;
                end
            end
            ST_MEAS_TX: begin
                if (tx_fire) begin
                    meas_left_nx = meas_left - ONE;
                    if (meas_left == ONE) state_nx = ST_END_TX;
                end
            end
            ST_END_TX, ST_END_WAIT: begin
                if (hit_result) begin
                    state_nx = ST_QUIET;
                end else if ((state == ST_END_TX) && tx_fire) begin
                    state_nx = ST_END_WAIT;
                end else if (retx_expire) begin
                    state_nx = ST_END_TX;
                end
            end
            ST_QUIET: begin
                if (hit_synch) state_nx = ST_ACKSYN_TX;
            end
            ST_ACKSYN_TX: begin
                if (tx_fire) state_nx = ST_NORMAL;
            end
            default: state_nx = ST_NORMAL;
        endcase
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_NORMAL;
            meas_left <= '0;
        end else begin
            state     <= state_nx;
            meas_left <= meas_left_nx;
        end
    end

    // Mode register: updated only when Result End is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_QPSK;
        end else if (((state == ST_END_TX) || (state == ST_END_WAIT)) && hit_result) begin
            mode_q <= mode_decided;
        end
    end
endmodule

// File: rtl/msw_initiator_chk.sv
// Protocol checker for the initiator controller, attached by bind.
// Observes ports only.
module msw_initiator_chk #(
    parameter int CNT_W = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic [7:0] tx_type,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       rx_bcast,
    input logic [7:0] rx_type,
    input logic       data_tx_grant,
    input logic       link_mode,
    input logic       busy
);
    // R10
    held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_type)));

    // R9
    grant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !data_tx_grant);

    // R3
    type_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_type == 8'd2) || (tx_type == 8'd4) ||
                      (tx_type == 8'd5) || (tx_type == 8'd8)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);

    // R7
    mode_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_mode) |-> (busy && !tx_valid));

    // R6
    mode_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_mode) |-> $past(rx_valid && rx_bcast && (rx_type == 8'd6)));
endmodule

bind msw_initiator_ctrl msw_initiator_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_valid      (tx_valid),
    .tx_type       (tx_type),
    .tx_ready      (tx_ready),
    .rx_valid      (rx_valid),
    .rx_bcast      (rx_bcast),
    .rx_type       (rx_type),
    .data_tx_grant (data_tx_grant),
    .link_mode     (link_mode),
    .busy          (busy)
);

// File: tb/msw_initiator_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for the mode-switch initiator: directed corners plus seeded random handshakes.
module msw_initiator_ctrl_tb;
    localparam int AUTO = 300;
    localparam int MAN  = 16;
    localparam int RETX = 10;
    localparam int CW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          manual_req = 1'b0;
    logic [CW-1:0] cfg_meas_count = '0;
    logic [CW-1:0] cfg_err_limit = '0;
    logic          tx_valid;
    logic [7:0]    tx_type;
    logic          tx_ready = 1'b1;
    logic          rx_valid = 1'b0;
    logic          rx_bcast = 1'b0;
    logic [7:0]    rx_type = '0;
    logic [CW-1:0] rx_payload = '0;
    logic          data_tx_req = 1'b0;
    logic          data_tx_grant;
    logic          link_mode;
    logic          busy;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    int  n_start = 0, n_meas = 0, n_end = 0, n_acks = 0;
    bit  rand_ready = 1'b0;
    bit  stall = 1'b0;
    bit  done = 1'b0;
    logic mode_model = 1'b0;

    msw_initiator_ctrl #(
        .AUTO_INTERVAL (AUTO),
        .MANUAL_DELAY  (MAN),
        .RETX_CYCLES   (RETX),
        .CNT_W         (CW)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .manual_req     (manual_req),
        .cfg_meas_count (cfg_meas_count),
        .cfg_err_limit  (cfg_err_limit),
        .tx_valid       (tx_valid),
        .tx_type        (tx_type),
        .tx_ready       (tx_ready),
        .rx_valid       (rx_valid),
        .rx_bcast       (rx_bcast),
        .rx_type        (rx_type),
        .rx_payload     (rx_payload),
        .data_tx_req    (data_tx_req),
        .data_tx_grant  (data_tx_grant),
        .link_mode      (link_mode),
        .busy           (busy)
    );

    always #2 clk = ~clk;

    // Watchdog and cycle count
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Peer model: drives ready and counts accepted requests by type
    always @(negedge clk) begin
        if (stall) tx_ready = 1'b0;
        else if (rand_ready) tx_ready = 1'($urandom_range(0, 1));
        else tx_ready = 1'b1;
        if (tx_valid && tx_ready) begin
            case (tx_type)
                8'd2: n_start = n_start + 1;
                8'd4: n_meas  = n_meas + 1;
                8'd5: n_end   = n_end + 1;
                8'd8: n_acks  = n_acks + 1;
                default: ;
            endcase
        end
    end

    function automatic logic exp_mode(input logic m, input int err, input int lim);
        if (!m && err < lim) return 1'b1;
        if (m && err > lim) return 1'b0;
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_rx(input logic [7:0] t, input int pl, input logic bc);
        @(negedge clk);
        rx_valid = 1'b1; rx_type = t; rx_payload = CW'(pl); rx_bcast = bc;
        @(negedge clk);
        rx_valid = 1'b0; rx_bcast = 1'b0; rx_type = '0;
    endtask

    task automatic clear_counts();
        n_start = 0; n_meas = 0; n_end = 0; n_acks = 0;
    endtask

    // Number of falling edges with the request withdrawn before it returns
    task automatic gap_len(output int g);
        g = 0;
        for (int i = 0; i < 200 && tx_valid; i++) @(negedge clk);
        for (int i = 0; i < 200 && !tx_valid; i++) begin
            @(negedge clk);
            g++;
        end
    endtask

    // One full handshake with the peer answering after the given retries
    task automatic run_hs(input int cnt, input int err, input int lim,
                          input int rs, input int re);
        logic em;
        bit   quiet_ok;
        em = exp_mode(mode_model, err, lim);
        cfg_meas_count = CW'(cnt);
        cfg_err_limit  = CW'(lim);
        if (!busy) begin
            clear_counts();
            @(negedge clk); manual_req = 1'b1;
            @(negedge clk); manual_req = 1'b0;
            for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
        end
        for (int i = 0; i < 4000 && n_start < rs + 1; i++) @(negedge clk);
        send_rx(8'd3, 0, 1'b1);
        for (int i = 0; i < 20000 && n_end < re + 1; i++) @(negedge clk);
        check(n_meas == cnt, "R4 measurement count", n_meas, cnt);
        data_tx_req = 1'b1;
        @(negedge clk);
        check(data_tx_grant == 1'b0, "R9 grant while busy", data_tx_grant, 0);
        data_tx_req = 1'b0;
        send_rx(8'd6, err, 1'b1);
        check(link_mode == em, "R6 mode decision", link_mode, em);
        mode_model = em;
        quiet_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (tx_valid || !busy) quiet_ok = 1'b0;
            @(negedge clk);
        end
        check(quiet_ok, "R7 silent after result", tx_valid, 0);
        send_rx(8'd7, 0, 1'b1);
        for (int i = 0; i < 200 && n_acks < 1; i++) @(negedge clk);
        @(negedge clk);
        check(!busy && n_acks == 1, "R7 single ack synch then normal", n_acks, 1);
    endtask

    initial begin
        int g;
        void'($urandom(32'h1D0C_5EED));
        repeat (4) @(negedge clk);
        check(!busy && !tx_valid && !link_mode, "R11 reset state", busy, 0);
        rst_n = 1'b1;
        check(!busy && !tx_valid && !link_mode, "R11 state after reset", tx_valid, 0);

        // R1 automatic trigger edge
        repeat (AUTO) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1 busy low before expiry", busy, 0);
        stall = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(busy == 1'b1 && tx_valid && tx_type == 8'd2, "R1 busy and Start at expiry", tx_type, 2);

        // R10 held request
        repeat (4) @(negedge clk);
        check(tx_valid && tx_type == 8'd2, "R10 request held without ready", tx_type, 2);
        stall = 1'b0;

        // R3 Start retransmit gap
        gap_len(g);
        check(g == RETX + 1 && tx_type == 8'd2, "R3 Start resend gap", g, RETX + 1);

        // R8 ignored replies during the Start phase
        clear_counts();
        send_rx(8'd3, 0, 1'b0);
        send_rx(8'd6, 0, 1'b1);
        repeat (30) @(negedge clk);
        check(n_meas == 0 && n_start >= 1 && busy, "R8 ignored Ack Start without broadcast", n_meas, 0);

        // R4 zero count goes straight to End
        cfg_meas_count = '0;
        cfg_err_limit  = CW'(10);
        send_rx(8'd3, 0, 1'b1);
        check(tx_valid && tx_type == 8'd5, "R4 zero count to End", tx_type, 5);

        // R5 End retransmit gap
        gap_len(g);
        check(g == RETX + 1 && tx_type == 8'd5, "R5 End resend gap", g, RETX + 1);

        // R8 ignored Result End without broadcast
        send_rx(8'd6, 0, 1'b0);
        gap_len(g);
        check(link_mode == 1'b0 && tx_type == 8'd5, "R8 ignored Result End", link_mode, 0);

        // R6 step up from QPSK
        send_rx(8'd6, 0, 1'b1);
        check(link_mode == 1'b1 && !tx_valid, "R6 step up below limit", link_mode, 1);
        mode_model = 1'b1;

        // R8 ignored Synch without broadcast keeps silence
        send_rx(8'd7, 0, 1'b0);
        repeat (5) @(negedge clk);
        check(!tx_valid && busy, "R8 ignored Synch", tx_valid, 0);
        send_rx(8'd7, 0, 1'b1);
        check(tx_valid && tx_type == 8'd8, "R7 Ack Synch requested", tx_type, 8);
        @(negedge clk);
        check(!busy, "R7 normal after Ack Synch", busy, 0);

        // R9 grant in normal operation
        data_tx_req = 1'b1;
        @(negedge clk);
        check(data_tx_grant == 1'b1, "R9 grant when idle", data_tx_grant, 1);
        data_tx_req = 1'b0;

        // R2 manual trigger timing
        clear_counts();
        manual_req = 1'b1;
        @(negedge clk);
        manual_req = 1'b0;
        repeat (MAN) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R2 busy low before manual expiry", busy, 0);
        @(posedge clk);
        @(negedge clk);
        check(busy == 1'b1, "R2 busy at manual expiry", busy, 1);

        // R6 equality keeps mode, then above limit steps down
        run_hs(3, 20, 20, 0, 0);
        run_hs(5, 40, 20, 1, 1);
        // R4 default-size measurement run
        run_hs(2000, 2, 30, 0, 0);

        // Seeded random handshakes
        rand_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            run_hs(int'($urandom_range(1, 30)), int'($urandom_range(0, 60)),
                   int'($urandom_range(5, 50)), int'($urandom_range(0, 2)),
                   int'($urandom_range(0, 2)));
        end
        rand_ready = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule